// File: doc/BRIEF.md
# One-Pin Pulse-Count Configuration Decoder

This block sits behind a single control pin of an audio power stage and turns activity on that pin into configuration. A host selects a setting by sending a burst of low-then-high pulses. The number of pulses in the burst is the command. The burst is taken as complete once the pin has stayed high for a latch window. If the pin is held low for a longer shutdown window, the amplifier is switched off. The next rising level wakes it again with the power-on settings.

The pin is brought through a configurable synchronizer and a minimum-width filter. High or low excursions shorter than the filter window are therefore not seen as edges. The decoded settings are held in registers and presented as plain fields: amplifier enable, gain-control enable, gain select, distortion-limit code, limiter mode and output-swing limit code. A one-cycle strobe marks every accepted command. All time windows are parameters counted in clock cycles.

Top module: `swcfg_decoder`

## Requirements
- R1: While reset is asserted and after it is released with the pin low, `amp_en_o` is 0, `cfg_stb_o` is 0, and the fields hold the power-on values: `agc_en_o`=1, `gain_hi_o`=1, `thd_code_o`=0, `nc_only_o`=0, `plim_code_o`=7.
- R2: With the amplifier off, a filtered rising level sets `amp_en_o` to 1 and reloads the power-on values. That rising edge is not counted as a pulse.
- R3: With the amplifier on, a filtered low level lasting `SHUT_CYC` cycles clears `amp_en_o`. The configuration fields keep their values. A shorter low level is an ordinary pulse.
- R4: A burst is acted on when the filtered level has stayed high for `LATCH_CYC` cycles after its last rising edge. An accepted command raises `cfg_stb_o` for exactly one cycle.
- R5: Count 1 sets `agc_en_o` to 0. Count 2 sets it to 1. Count 3 reloads all power-on values.
- R6: Count 4 sets `gain_hi_o` to 0 (lower gain step, 12 dB). Count 5 sets it to 1 (18 dB).
- R7: Counts 6 to 13 set `thd_code_o` to count minus 6. Codes 0 to 7 stand for limits of 1, 2, 4, 6, 8, 10, 15 and 20 percent.
- R8: Count 14 sets `nc_only_o` to 0 (clip prevention together with the swing limit). Count 15 sets it to 1 (clip prevention alone).
- R9: Counts 16 to 23 set `plim_code_o` to count minus 16. Code k stands for a peak limit of 0.45*(k+1) V.
- R10: A burst of more than 23 pulses changes no field and gives no strobe. The pulse counter saturates and never wraps, so 33 pulses are ignored too.
- R11: A high or low excursion shorter than `MIN_PULSE_CYC` cycles, after synchronization, is neither counted nor allowed to restart a timing window.
- R12: The configuration fields change only in the cycle of an accepted command or of a wake-up. While a burst is in progress they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_pin_i | input | 1 | Raw single-wire control pin |
| amp_en_o | output | 1 | Amplifier enable |
| agc_en_o | output | 1 | Automatic gain control enable |
| gain_hi_o | output | 1 | Gain select: 0 = 12 dB, 1 = 18 dB |
| thd_code_o | output | 3 | Distortion-limit code |
| nc_only_o | output | 1 | Limiter mode: 1 = clip prevention only |
| plim_code_o | output | 3 | Peak output limit code |
| cfg_stb_o | output | 1 | One-cycle pulse when a command is applied |

## Verification
A pulse counter that is off by one shows up at the ports as the neighbouring setting, one latch window after the burst ends. The tests therefore walk every count across the whole distortion and swing tables. A counter that wraps instead of saturating turns a 33-pulse burst into command 1, which would clear the gain-control enable within one latch window. A filter or timer that reacts to short glitches either adds pulses to a burst or restarts the latch window. That is exposed by a wrong field value or a missing strobe. A wrong shutdown or wake state shows up directly on the enable output and on whether the power-on values come back.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;

   localparam int THD_W       = 3;
   localparam int PLIM_W      = 3;
   localparam int CMD_LAST    = 23;
   localparam int CMD_THD_LO  = 6;
   localparam int CMD_THD_HI  = CMD_THD_LO + (1 << THD_W) - 1;
   localparam int CMD_PLIM_LO = 16;
   localparam int CMD_PLIM_HI = CMD_PLIM_LO + (1 << PLIM_W) - 1;

   typedef struct packed {
      logic              agc_en;
      logic              gain_hi;
      logic [THD_W-1:0]  thd;
      logic              nc_only;
      logic [PLIM_W-1:0] plim;
   } cfg_t;

   localparam cfg_t CFG_POWER_ON = '{agc_en: 1'b1, gain_hi: 1'b1, thd: '0,
                                     nc_only: 1'b0, plim: '1};

   function automatic logic cmd_known(input int unsigned n);
      return (n >= 1) && (n <= CMD_LAST);
   endfunction

   function automatic cfg_t cmd_apply(input int unsigned n, input cfg_t cur);
      cfg_t nxt;
      nxt = cur;
      if (n == 1)      nxt.agc_en  = 1'b0;
      else if (n == 2) nxt.agc_en  = 1'b1;
      else if (n == 3) nxt         = CFG_POWER_ON;
      else if (n == 4) nxt.gain_hi = 1'b0;
      else if (n == 5) nxt.gain_hi = 1'b1;
      else if (n >= CMD_THD_LO && n <= CMD_THD_HI)
         nxt.thd = THD_W'(n - CMD_THD_LO);
      else if (n == 14) nxt.nc_only = 1'b0;
      else if (n == 15) nxt.nc_only = 1'b1;
      else if (n >= CMD_PLIM_LO && n <= CMD_PLIM_HI)
         nxt.plim = PLIM_W'(n - CMD_PLIM_LO);
      return nxt;
   endfunction

endpackage

// File: rtl/swcfg_sync.sv
module swcfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               ff_q <= '0;
            end else begin
               ff_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
            end
         end
         assign q_o = ff_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/swcfg_deglitch.sv
module swcfg_deglitch #(
   parameter int MIN_CYC = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic lvl_o,
   output logic rise_o,
   output logic change_o
);
   localparam int CW = $clog2(MIN_CYC + 1);

   logic [CW-1:0] run_q;
   logic          lvl_q;
   logic          differ;
   logic          flip;

   assign differ = raw_i ^ lvl_q;
   assign flip   = differ && (run_q == CW'(MIN_CYC - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= '0;
         lvl_q <= 1'b0;
      end else if (!differ) begin
         run_q <= '0;
      end else if (flip) begin
         run_q <= '0;
         lvl_q <= raw_i;
      end else begin
         run_q <= run_q + CW'(1);
      end
   end

   assign lvl_o    = lvl_q;
   assign rise_o   = flip & raw_i;
   assign change_o = flip;
endmodule

// File: rtl/swcfg_seq.sv
module swcfg_seq #(
   parameter int LATCH_CYC = 350,
   parameter int SHUT_CYC  = 450,
   parameter int CNT_W     = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             lvl_i,
   input  logic             rise_i,
   input  logic             change_i,
   output logic             amp_en_o,
   output logic             wake_o,
   output logic             latch_o,
   output logic [CNT_W-1:0] cmd_o
);
   localparam int LIM = (LATCH_CYC > SHUT_CYC) ? LATCH_CYC : SHUT_CYC;
   localparam int TW  = $clog2(LIM + 1);
   localparam logic [CNT_W-1:0] CNT_SAT = '1;

   typedef enum logic {ST_OFF, ST_ON} st_e;

   st_e              st_q;
   logic [TW-1:0]    tmr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             high_to;
   logic             low_to;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               tmr_q <= '0;
      else if (change_i)         tmr_q <= '0;
      else if (tmr_q != TW'(LIM)) tmr_q <= tmr_q + TW'(1);
   end

   assign high_to = (st_q == ST_ON) && lvl_i && !change_i
                    && (tmr_q == TW'(LATCH_CYC - 1));
   assign low_to  = (st_q == ST_ON) && !lvl_i && !change_i
                    && (tmr_q == TW'(SHUT_CYC - 1));
   assign wake_o  = (st_q == ST_OFF) && rise_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= ST_OFF;
      end else begin
         if (wake_o)      st_q <= ST_ON;
         else if (low_to) st_q <= ST_OFF;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (wake_o || high_to || low_to)
         cnt_q <= '0;
      else if ((st_q == ST_ON) && rise_i && (cnt_q != CNT_SAT))
         cnt_q <= cnt_q + CNT_W'(1);
   end

   assign amp_en_o = (st_q == ST_ON);
   assign latch_o  = high_to;
   assign cmd_o    = cnt_q;
endmodule

// File: rtl/swcfg_cfg_regs.sv
module swcfg_cfg_regs
   import swcfg_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wake_i,
   input  logic             latch_i,
   input  logic [CNT_W-1:0] cmd_i,
   output cfg_t             cfg_o,
   output logic             stb_o
);
   int unsigned cmd_n;
   logic        take;
   cfg_t        cfg_q;
   logic        stb_q;

   assign cmd_n = 32'(cmd_i);
   assign take  = latch_i && cmd_known(cmd_n);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= CFG_POWER_ON;
         stb_q <= 1'b0;
      end else begin
         stb_q <= take;
         if (wake_i)    cfg_q <= CFG_POWER_ON;
         else if (take) cfg_q <= cmd_apply(cmd_n, cfg_q);
      end
   end

   assign cfg_o = cfg_q;
   assign stb_o = stb_q;
endmodule

// File: rtl/swcfg_decoder.sv
module swcfg_decoder
   import swcfg_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int MIN_PULSE_CYC = 5,
   parameter int LATCH_CYC     = 350,
   parameter int SHUT_CYC      = 450,
   parameter int CNT_W         = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ctl_pin_i,
   output logic              amp_en_o,
   output logic              agc_en_o,
   output logic              gain_hi_o,
   output logic [THD_W-1:0]  thd_code_o,
   output logic              nc_only_o,
   output logic [PLIM_W-1:0] plim_code_o,
   output logic              cfg_stb_o
);
   generate
      if (CNT_W < 5) begin : g_chk_cnt
         $error("CNT_W must hold counts above the last command");
      end
      if (MIN_PULSE_CYC < 1) begin : g_chk_min
         $error("MIN_PULSE_CYC must be at least 1");
      end
      if (LATCH_CYC <= MIN_PULSE_CYC) begin : g_chk_latch
         $error("LATCH_CYC must exceed MIN_PULSE_CYC");
      end
      if (SHUT_CYC <= MIN_PULSE_CYC) begin : g_chk_shut
         $error("SHUT_CYC must exceed MIN_PULSE_CYC");
      end
   endgenerate

   logic             pin_s;
   logic             lvl;
   logic             rise;
   logic             change;
   logic             wake;
   logic             latch;
   logic [CNT_W-1:0] cmd;
   cfg_t             cfg;

   swcfg_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ctl_pin_i), .q_o(pin_s));

   swcfg_deglitch #(.MIN_CYC(MIN_PULSE_CYC)) dgl_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(pin_s),
      .lvl_o(lvl), .rise_o(rise), .change_o(change));

   swcfg_seq #(.LATCH_CYC(LATCH_CYC), .SHUT_CYC(SHUT_CYC), .CNT_W(CNT_W)) seq_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .rise_i(rise),
      .change_i(change), .amp_en_o(amp_en_o), .wake_o(wake),
      .latch_o(latch), .cmd_o(cmd));

   swcfg_cfg_regs #(.CNT_W(CNT_W)) regs_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .wake_i(wake), .latch_i(latch),
      .cmd_i(cmd), .cfg_o(cfg), .stb_o(cfg_stb_o));

   assign agc_en_o    = cfg.agc_en;
   assign gain_hi_o   = cfg.gain_hi;
   assign thd_code_o  = cfg.thd;
   assign nc_only_o   = cfg.nc_only;
   assign plim_code_o = cfg.plim;
endmodule

// File: rtl/swcfg_decoder_chk.sv
module swcfg_decoder_chk
   import swcfg_pkg::*;
(
   input logic              clk_i,
   input logic              rst_ni,
   input logic              amp_en_o,
   input logic              agc_en_o,
   input logic              gain_hi_o,
   input logic [THD_W-1:0]  thd_code_o,
   input logic              nc_only_o,
   input logic [PLIM_W-1:0] plim_code_o,
   input logic              cfg_stb_o
);
   // R4: an accepted command is a single-cycle pulse
   assert_stb_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_stb_o |=> !cfg_stb_o);

   // R3: commands are only taken while the amplifier is enabled
   assert_stb_needs_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_stb_o |-> amp_en_o);

   // R12: fields hold unless a command is applied or the amplifier wakes
   assert_fields_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_stb_o && !$rose(amp_en_o)) |->
         ($stable(agc_en_o) && $stable(gain_hi_o) && $stable(thd_code_o)
          && $stable(nc_only_o) && $stable(plim_code_o)));

   // R2: waking brings back the power-on values
   assert_wake_defaults_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(amp_en_o) |-> (agc_en_o && gain_hi_o && (thd_code_o == '0)
                           && !nc_only_o && (plim_code_o == '1)));
endmodule

bind swcfg_decoder swcfg_decoder_chk chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .amp_en_o(amp_en_o), .agc_en_o(agc_en_o),
   .gain_hi_o(gain_hi_o), .thd_code_o(thd_code_o), .nc_only_o(nc_only_o),
   .plim_code_o(plim_code_o), .cfg_stb_o(cfg_stb_o));

// File: tb/swcfg_decoder_tb_top.sv
`timescale 1ns/1ps
module swcfg_decoder_tb_top;
   localparam int MINC  = 4;
   localparam int LATCH = 40;
   localparam int SHUT  = 80;
   localparam int HALF  = 8;
   localparam int SETTLE = 70;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b0;
   logic       amp_en, agc_en, gain_hi, nc_only, cfg_stb;
   logic [2:0] thd_code, plim_code;

   int checks = 0;
   int fails  = 0;
   int stb_cnt = 0;
   bit done = 1'b0;

   int m_amp, m_agc, m_gain, m_thd, m_nc, m_plim;

   always #2.5 clk = ~clk;

   always @(posedge clk) if (rst_n && cfg_stb) stb_cnt++;

   swcfg_decoder #(.SYNC_STAGES(2), .MIN_PULSE_CYC(MINC), .LATCH_CYC(LATCH),
                   .SHUT_CYC(SHUT), .CNT_W(5)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ctl_pin_i(pin), .amp_en_o(amp_en),
      .agc_en_o(agc_en), .gain_hi_o(gain_hi), .thd_code_o(thd_code),
      .nc_only_o(nc_only), .plim_code_o(plim_code), .cfg_stb_o(cfg_stb));

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_val(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_defaults();
      m_agc = 1; m_gain = 1; m_thd = 0; m_nc = 0; m_plim = 7;
   endtask

   task automatic model_cmd(input int n);
      if (n == 1) m_agc = 0;
      else if (n == 2) m_agc = 1;
      else if (n == 3) model_defaults();
      else if (n == 4) m_gain = 0;
      else if (n == 5) m_gain = 1;
      else if (n >= 6 && n <= 13) m_thd = n - 6;
      else if (n == 14) m_nc = 0;
      else if (n == 15) m_nc = 1;
      else if (n >= 16 && n <= 23) m_plim = n - 16;
   endtask

   task automatic check_all(input string req);
      check_val(req, "amp_en", int'(amp_en), m_amp);
      check_val(req, "agc_en", int'(agc_en), m_agc);
      check_val(req, "gain_hi", int'(gain_hi), m_gain);
      check_val(req, "thd_code", int'(thd_code), m_thd);
      check_val(req, "nc_only", int'(nc_only), m_nc);
      check_val(req, "plim_code", int'(plim_code), m_plim);
   endtask

   task automatic send_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         pin = 1'b0; wait_cyc(HALF);
         pin = 1'b1; wait_cyc(HALF);
      end
   endtask

   task automatic do_cmd(input int n, input string req, input bit valid);
      int s0;
      s0 = stb_cnt;
      send_pulses(n);
      check_all("R12 pre-latch");
      check_val("R12 no early strobe", "stb", stb_cnt - s0, 0);
      wait_cyc(SETTLE);
      check_val(valid ? "R4" : "R10", "strobes", stb_cnt - s0, valid ? 1 : 0);
      if (valid) model_cmd(n);
      check_all(req);
   endtask

   task automatic t_reset();
      pin = 1'b0; rst_n = 1'b0;
      wait_cyc(5);
      m_amp = 0; model_defaults();
      check_all("R1 in reset");
      rst_n = 1'b1;
      wait_cyc(20);
      check_all("R1 after reset");
      check_val("R1", "stb", int'(cfg_stb), 0);
   endtask

   task automatic t_wake();
      pin = 1'b1;
      wait_cyc(20);
      m_amp = 1;
      check_all("R2 wake");
      wait_cyc(SETTLE);
      check_val("R2 wake edge not counted", "strobes", stb_cnt, 0);
   endtask

   task automatic t_agc();
      do_cmd(1, "R5 agc off", 1'b1);
      do_cmd(2, "R5 agc on", 1'b1);
      do_cmd(1, "R5 agc off", 1'b1);
      do_cmd(4, "R6 gain low", 1'b1);
      do_cmd(3, "R5 restore", 1'b1);
   endtask

   task automatic t_gain();
      do_cmd(4, "R6 gain 12dB", 1'b1);
      do_cmd(5, "R6 gain 18dB", 1'b1);
   endtask

   task automatic t_thd();
      for (int n = 6; n <= 13; n++) do_cmd(n, "R7 thd", 1'b1);
   endtask

   task automatic t_mode();
      do_cmd(15, "R8 clip-only", 1'b1);
      do_cmd(14, "R8 clip+limit", 1'b1);
   endtask

   task automatic t_plim();
      for (int n = 16; n <= 23; n++) do_cmd(n, "R9 plim", 1'b1);
   endtask

   task automatic t_ignore();
      do_cmd(24, "R10 count 24", 1'b0);
      do_cmd(33, "R10 saturate 33", 1'b0);
   endtask

   task automatic t_glitch();
      int s0;
      do_cmd(4, "R11 setup", 1'b1);
      s0 = stb_cnt;
      for (int i = 0; i < 5; i++) begin
         pin = 1'b0; wait_cyc(HALF);
         pin = 1'b1; wait_cyc(MINC - 2);
         pin = 1'b0; wait_cyc(HALF);
         pin = 1'b1; wait_cyc(HALF);
         pin = 1'b0; wait_cyc(MINC - 2);
         pin = 1'b1; wait_cyc(HALF);
      end
      wait_cyc(SETTLE);
      check_val("R11 glitches ignored", "strobes", stb_cnt - s0, 1);
      model_cmd(5);
      check_all("R11 count of 5");
   endtask

   task automatic t_shutdown();
      do_cmd(9, "R3 setup", 1'b1);
      pin = 1'b0; wait_cyc(SHUT - 20);
      pin = 1'b1; wait_cyc(SETTLE);
      model_cmd(1);
      check_all("R3 long low is a pulse");
      pin = 1'b0; wait_cyc(SHUT + 40);
      m_amp = 0;
      check_all("R3 shutdown holds fields");
      pin = 1'b1; wait_cyc(20);
      m_amp = 1; model_defaults();
      check_all("R2 re-wake defaults");
   endtask

   initial begin
      t_reset();
      t_wake();
      t_agc();
      t_gain();
      t_thd();
      t_mode();
      t_plim();
      t_ignore();
      t_glitch();
      t_shutdown();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule